// File: doc/BRIEF.md
# Byte-Merging Data FIFO Port

This block sits between a 32-bit register bus and a byte-wide serial shift engine. Software writes outgoing bytes into a transmit FIFO through a single data register and reads incoming bytes from a receive FIFO through the same register. The serial engine takes transmit bytes and delivers receive bytes over a simple pop/push handshake. A format bit selects how much each data access moves. With the bit clear, an access moves one byte in bits 7:0. With the bit set, it moves four packed bytes, and the least significant byte goes first on the serial side.

The block reports its FIFO depths through a read-only configuration word. Each depth is coded as a log2 value. Status bits flag a full transmit FIFO, an empty receive FIFO and sticky overflow and underrun errors. Control bits clear the whole port or either FIFO. Each of these bits clears itself once its reset has been carried out. Two further control bits enable per-direction DMA requests, which are sized so that an external DMA engine can move half a FIFO per burst.

Top module: `spi_byte_merge_port`

## Requirements
- R1: After reset, status reads 0x0000_4000 (only receive-empty set), control and format read 0, `tx_avail` is 0, `rx_room` is 1 and both DMA requests are 0.
- R2: With format bit 7 clear, a write to the data register (address 3) queues only bits 7:0 as one transmit byte.
- R3: With format bit 7 set, a data write queues four bytes in the order bits 7:0, 15:8, 23:16, 31:24.
- R4: A data read (address 3) returns and removes one receive byte in bits 7:0 with upper bits zero. In merge mode it removes four bytes, with the oldest byte in bits 7:0.
- R5: Status (address 2) bit 23 is 1 exactly when the transmit FIFO holds its full depth, and bit 14 is 1 exactly when the receive FIFO is empty.
- R6: A data write that needs more free entries than the transmit FIFO has is dropped whole and sets sticky status bit 24. A data read that needs more bytes than the receive FIFO holds returns 0, removes nothing and sets sticky status bit 15.
- R7: Control (address 1) bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Each reads back 1 in the cycle after the write and 0 once the reset is done, and leaves the other FIFO untouched.
- R8: Control bit 0 empties both FIFOs and clears the format register, the control register and both sticky error bits, then reads back 0.
- R9: Configuration (address 4) returns the receive depth code in bits 3:0 and the transmit depth code in bits 7:4, where depth equals 2^(code+1).
- R10: `tx_dma_req` is 1 exactly when control bit 4 is set and at least half of the transmit FIFO is free.
- R11: `rx_dma_req` is 1 exactly when control bit 3 is set and either at least half of the receive FIFO is filled, or `xfer_end` is 1 and at least one byte is held.
- R12: `tx_avail` is 1 while the transmit FIFO holds a byte, and `tx_pop` has no effect while it is 0. `rx_room` is 0 while the receive FIFO is full, and a push in that state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read pops in this cycle) |
| bus_addr | input | 3 | Word address: 0 format, 1 control, 2 status, 3 data, 4 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| tx_pop | input | 1 | Serial engine takes `tx_byte` |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Serial engine delivers `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive FIFO not full |
| xfer_end | input | 1 | Serial transfer is ending; flush remaining receive bytes by DMA |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Pointer corruption shows up as a wrong or reordered byte at `tx_byte`, or as a wrong packed word on a data read. The bench sees it on the next pop or read, because every expected byte comes from a scoreboard queue. A miscounted fill level shows as wrong full/empty status or a wrong DMA request level in the same cycle that the count changes. A reset bit that does not clear itself, or that clears the wrong FIFO, shows in the control readback one cycle later and in the `tx_avail` and receive-empty flags right after.

// File: rtl/spi_byte_merge_port.sv
module spi_byte_merge_port #(
  parameter int TX_CODE = 2,
  parameter int RX_CODE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tx_pop,
  output logic        tx_avail,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        rx_room,
  input  logic        xfer_end,
  output logic        tx_dma_req,
  output logic        rx_dma_req
);
  localparam int TXA = TX_CODE + 1;
  localparam int RXA = RX_CODE + 1;
  localparam int TXD = 1 << TXA;
  localparam int RXD = 1 << RXA;
  localparam logic [TXA:0] TX_FULLV = (TXA+1)'(TXD);
  localparam logic [TXA:0] TX_HALF  = (TXA+1)'(TXD / 2);
  localparam logic [TXA:0] TX_FOUR  = (TXA+1)'(4);
  localparam logic [TXA:0] TX_ONE   = (TXA+1)'(1);
  localparam logic [RXA:0] RX_FULLV = (RXA+1)'(RXD);
  localparam logic [RXA:0] RX_HALF  = (RXA+1)'(RXD / 2);
  localparam logic [RXA:0] RX_FOUR  = (RXA+1)'(4);
  localparam logic [RXA:0] RX_ONE   = (RXA+1)'(1);
  localparam logic [2:0] A_FMT = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_DATA = 3'd3, A_CFG = 3'd4;

  logic         merge, tx_ovf, rx_unf;
  logic [4:0]   ctrl_q;
  logic [TXA:0] tx_wp, tx_rp, tx_cnt, tx_n;
  logic [RXA:0] rx_wp, rx_rp, rx_cnt, rx_n;
  logic [7:0]   tx_mem [TXD];
  logic [7:0]   rx_mem [RXD];
  logic [31:0]  rx_word;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_data = bus_rd && bus_addr == A_DATA;
  wire rst_all = ctrl_q[0];
  wire rst_rx  = ctrl_q[0] | ctrl_q[1];
  wire rst_tx  = ctrl_q[0] | ctrl_q[2];

  assign tx_cnt = tx_wp - tx_rp;
  assign rx_cnt = rx_wp - rx_rp;
  assign tx_n   = merge ? TX_FOUR : TX_ONE;
  assign rx_n   = merge ? RX_FOUR : RX_ONE;

  wire tx_ok   = (TX_FULLV - tx_cnt) >= tx_n;
  wire rx_ok   = rx_cnt >= rx_n;
  wire tx_push = wr_data && tx_ok;
  wire rx_pull = rd_data && rx_ok;
  wire tx_take = tx_pop && tx_avail;
  wire rx_put  = rx_push && rx_room;

  assign tx_avail = tx_cnt != '0;
  assign rx_room  = rx_cnt != RX_FULLV;
  assign tx_byte  = tx_mem[tx_rp[TXA-1:0]];

  assign tx_dma_req = ctrl_q[4] && (TX_FULLV - tx_cnt) >= TX_HALF;
  assign rx_dma_req = ctrl_q[3] && (rx_cnt >= RX_HALF || (xfer_end && rx_cnt != '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else if (rst_tx) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + tx_n;
      if (tx_take) tx_rp <= tx_rp + TX_ONE;
    end

  always_ff @(posedge clk)
    if (tx_push && !rst_tx)
      for (int k = 0; k < 4; k++)
        if (k == 0 || merge) tx_mem[tx_wp[TXA-1:0] + TXA'(k)] <= bus_wdata[8*k +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else if (rst_rx) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (rx_put)  rx_wp <= rx_wp + RX_ONE;
      if (rx_pull) rx_rp <= rx_rp + rx_n;
    end

  always_ff @(posedge clk)
    if (rx_put && !rst_rx) rx_mem[rx_wp[RXA-1:0]] <= rx_byte;

  always_comb
    for (int k = 0; k < 4; k++)
      rx_word[8*k +: 8] = (k == 0 || merge) ? rx_mem[rx_rp[RXA-1:0] + RXA'(k)] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      merge  <= 1'b0;
      ctrl_q <= '0;
      tx_ovf <= 1'b0;
      rx_unf <= 1'b0;
    end else begin
      ctrl_q <= {ctrl_q[4:3], 3'b000};
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[4:0];
      if (bus_wr && bus_addr == A_FMT)  merge  <= bus_wdata[7];
      if (wr_data && !tx_ok) tx_ovf <= 1'b1;
      if (rd_data && !rx_ok) rx_unf <= 1'b1;
      if (rst_all) begin
        merge  <= 1'b0;
        ctrl_q <= '0;
        tx_ovf <= 1'b0;
        rx_unf <= 1'b0;
      end
    end

  always_comb
    case (bus_addr)
      A_FMT:   bus_rdata = {24'h0, merge, 7'h0};
      A_CTRL:  bus_rdata = {27'h0, ctrl_q};
      A_STAT:  bus_rdata = {7'h0, tx_ovf, tx_cnt == TX_FULLV, 7'h0, rx_unf, rx_cnt == '0, 14'h0};
      A_DATA:  bus_rdata = rx_ok ? rx_word : 32'h0;
      A_CFG:   bus_rdata = {24'h0, 4'(TX_CODE), 4'(RX_CODE)};
      default: bus_rdata = 32'h0;
    endcase
endmodule

module spi_byte_merge_port_chk #(
  parameter int TXA = 3,
  parameter int RXA = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   ctrl_q,
  input logic [TXA:0] tx_cnt,
  input logic [RXA:0] rx_cnt,
  input logic         merge,
  input logic         tx_ovf,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic         tx_pop,
  input logic         tx_avail,
  input logic         tx_dma_req,
  input logic         rx_dma_req
);
  localparam logic [TXA:0] TXD = (TXA+1)'(1 << TXA);
  localparam logic [RXA:0] RXD = (RXA+1)'(1 << RXA);

  a_r7_reset_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:0] != 3'b0 && !(bus_wr && bus_addr == 3'd1)) |=> ctrl_q[2:0] == 3'b0);
  a_r8_core_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |=> (tx_cnt == '0 && rx_cnt == '0 && !merge && !tx_ovf));
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !ctrl_q[0]) |=> tx_ovf);
  a_r5_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TXD && rx_cnt <= RXD);
  a_r10_tx_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> ctrl_q[4]);
  a_r11_rx_dma_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (ctrl_q[3] && rx_cnt != '0));
  a_r12_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !tx_avail && !(bus_wr && bus_addr == 3'd3) && ctrl_q[2:0] == 3'b0) |=> tx_cnt == '0);
endmodule

bind spi_byte_merge_port spi_byte_merge_port_chk #(.TXA(TXA), .RXA(RXA)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .merge(merge), .tx_ovf(tx_ovf), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

// File: tb/test_spi_byte_merge_port.sv
module test_spi_byte_merge_port;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0, xfer_end = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, v;
  logic [7:0]  rx_byte = '0, tx_byte;
  logic tx_avail, rx_room, tx_dma_req, rx_dma_req;

  spi_byte_merge_port i_spi_byte_merge_port (.*);

  int n_chk = 0, n_bad = 0;
  bit fin = 0, drain = 0;
  string cur_tag = "R2";
  logic [7:0] txq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rx_put(logic [7:0] b);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic send(logic [31:0] w, bit m);
    for (int k = 0; k < (m ? 4 : 1); k++) txq.push_back(w[8*k +: 8]);
    wr(3'd3, w);
  endtask

  task automatic drain_all();
    drain = 1;
    wait (txq.size() == 0);
    @(negedge clk);
    @(negedge clk);
    drain = 0;
  endtask

  initial forever begin
    @(negedge clk);
    tx_pop = 0;
    if (drain && tx_avail) begin
      if (txq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected tx byte actual=%h expected=none", tx_byte);
      end else chk(cur_tag, {24'h0, tx_byte}, {24'h0, txq.pop_front()});
      tx_pop = 1;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd2, v); chk("R1 status", v, 32'h0000_4000);
    rd(3'd1, v); chk("R1 control", v, 32'h0);
    rd(3'd0, v); chk("R1 format", v, 32'h0);
    chk("R1 outputs", {tx_avail, rx_room, tx_dma_req, rx_dma_req}, 4'b0100);
    rd(3'd4, v); chk("R9 config", v, 32'h21);

    cur_tag = "R2 single byte";
    send(32'hAABB_CC11, 0);
    send(32'h0000_00F0, 0);
    drain_all();

    wr(3'd0, 32'h80);
    cur_tag = "R3 merge order";
    send(32'h4433_2211, 1);
    send(32'h8877_6655, 1);
    drain_all();

    wr(3'd1, 32'h10);
    chk("R10 tx dma empty", tx_dma_req, 1);
    send(32'hA3A2_A1A0, 1);
    chk("R10 tx dma half free", tx_dma_req, 1);
    send(32'hB3B2_B1B0, 1);
    chk("R10 tx dma full", tx_dma_req, 0);
    rd(3'd2, v); chk("R5 tx full", v, 32'h0080_4000);
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd2, v); chk("R6 overflow sticky", v, 32'h0180_4000);
    cur_tag = "R6 drop whole word";
    drain_all();
    chk("R6 no extra bytes", tx_avail, 0);

    wr(3'd0, 32'h0);
    rx_put(8'h5A);
    rd(3'd3, v); chk("R4 single read", v, 32'h5A);
    rd(3'd3, v); chk("R6 underrun zero", v, 32'h0);
    rd(3'd2, v); chk("R6 underrun sticky", v, 32'h0100_C000);

    wr(3'd0, 32'h80);
    wr(3'd1, 32'h18);
    rx_put(8'h01);
    chk("R11 rx dma below half", rx_dma_req, 0);
    xfer_end = 1;
    #1 chk("R11 rx dma tail", rx_dma_req, 1);
    xfer_end = 0;
    rx_put(8'h02);
    chk("R11 rx dma half", rx_dma_req, 1);
    rx_put(8'h03);
    rx_put(8'h04);
    chk("R12 rx full", rx_room, 0);
    rx_put(8'h99);
    rd(3'd3, v); chk("R4 merge read", v, 32'h0403_0201);
    rd(3'd2, v); chk("R12 push ignored", v, 32'h0100_C000);

    rx_put(8'h11);
    rx_put(8'h22);
    rd(3'd3, v); chk("R6 merge underrun", v, 32'h0);
    wr(3'd0, 32'h0);
    rd(3'd3, v); chk("R6 nothing removed", v, 32'h11);
    rd(3'd3, v); chk("R4 next byte", v, 32'h22);

    send(32'h77, 0);
    rx_put(8'h33);
    wr(3'd1, 32'h1A);
    rd(3'd1, v); chk("R7 rx reset bit set", v, 32'h1A);
    rd(3'd1, v); chk("R7 rx reset bit cleared", v, 32'h18);
    rd(3'd2, v); chk("R7 rx emptied", v[14], 1);
    chk("R7 tx untouched", tx_avail, 1);
    wr(3'd1, 32'h1C);
    rd(3'd1, v); chk("R7 tx reset bit set", v, 32'h1C);
    chk("R7 tx emptied", tx_avail, 0);
    txq.delete();

    wr(3'd0, 32'h80);
    send(32'h1234_5678, 1);
    txq.delete();
    rx_put(8'h44);
    wr(3'd1, 32'h19);
    rd(3'd1, v); chk("R8 core bit set", v, 32'h19);
    rd(3'd0, v); chk("R8 format cleared", v, 32'h0);
    rd(3'd1, v); chk("R8 control cleared", v, 32'h0);
    rd(3'd2, v); chk("R8 status cleared", v, 32'h0000_4000);
    chk("R8 outputs", {tx_avail, tx_dma_req, rx_dma_req}, 3'b000);

    fin = 1;
    summary();
    $finish;
  end
endmodule